// File: doc/BRIEF.md
# Power-Up Strap Latch and Frequency Code Select

This block owns the configuration straps that share pins with clock outputs. While reset is active and for a fixed window after it, the shared pins stay in input mode and the downstream clock drivers stay low. At the end of the window it captures the four frequency-select straps and the serial-I/O rate strap in one clock cycle. It then turns the pins into outputs by raising `pad_oe`. The window length is computed from the reference clock frequency and a window time given in microseconds. With the defaults (14.31818 MHz, 2000 us) the window is 28636 reference cycles.

Once the pins are outputs, the block registers the effective five-bit frequency code. While the override input is low, the code is the latched strap nibble with a zero spread bit on top, so spread spectrum is off. While override is high, the code is the five-bit register value, and its top bit turns on the ±0.5 % spread. The low nibble value 1110 is reserved in both sources. A reserved selection is refused: the block keeps the last accepted code and raises an error flag. Each time a code is accepted that differs from the held one, or the first time any code is accepted, the block raises a one-cycle strobe so the divider logic downstream can reload. All pins are plain control and status levels. No stream interface is present, so no back-pressure applies.

Top module: `freq_strap_ctrl`

## Requirements
- R1: While reset is active and during the strap window, `pad_oe` is 0. In the same period `freq_code`/`spread_en` show the reset code (default 0_1101), `code_err` is 0, `code_upd` is 0 and `sio_rate_24` is 0.
- R2: `pad_oe` rises at exactly the WIN-th rising clock edge after reset release, where WIN = REF_HZ*WINDOW_US/1e6 (integer). Once high, it stays high until the next reset.
- R3: The strap inputs are sampled at the edge where `pad_oe` rises. Later changes on the strap inputs have no effect.
- R4: `sio_rate_24` is 1 (24 MHz) when the serial-I/O strap was latched high, and 0 (48 MHz) when it was latched low.
- R5: While `cfg_override` is 0, the effective code is {0, FS3..FS0}: `freq_code` equals the strap nibble, `spread_en` is 0, and `cfg_sel` has no effect.
- R6: While `cfg_override` is 1, `spread_en` is `cfg_sel[4]` and `freq_code` is `cfg_sel[3:0]`.
- R7: When the selected low nibble is 1110, the outputs keep the previously accepted code and `code_err` becomes 1. `code_err` returns to 0 once a non-reserved code is selected.
- R8: `code_upd` pulses for one cycle when a non-reserved code is accepted that differs from the held code, and on the first acceptance after reset. It is otherwise 0.
- R9: The effective code is registered. It reflects the selection one clock edge after `pad_oe` rises, and one edge after any change of `cfg_override`/`cfg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset (power-on) |
| fs_pad_in | input | 4 | Frequency-select strap levels read from the shared pins |
| sio_pad_in | input | 1 | Serial-I/O rate strap level (1 = 24 MHz, 0 = 48 MHz) |
| pad_oe | output | 1 | 1 once the shared pins become clock outputs; clocks held low while 0 |
| sio_rate_24 | output | 1 | Latched serial-I/O rate select |
| cfg_override | input | 1 | Configuration bit: use `cfg_sel` instead of the straps |
| cfg_sel | input | 5 | Register code: bit 4 spread enable, bits 3..0 frequency code |
| freq_code | output | 4 | Effective frequency code |
| spread_en | output | 1 | Effective spread-spectrum enable |
| code_err | output | 1 | Current selection is reserved and was refused |
| code_upd | output | 1 | One-cycle strobe on a change of the effective code |

## Verification
The assertions take for granted that the strap pins are stable around the end of the window, because the latch has no synchronizer. They also assume that `cfg_override` and `cfg_sel` are synchronous to `clk`. The stimulus drives every input on the falling edge only. It holds the straps fixed from reset until the latch edge and changes them only after the latch, to show that later changes are ignored. The configuration sweep steps once per cycle, so every accept, refuse and strobe decision is seen on a separate edge.

// File: rtl/freq_strap_pkg.sv
package freq_strap_pkg;
  localparam int FS_W   = 4;
  localparam int CODE_W = FS_W + 1;
  typedef logic [CODE_W-1:0] sel_code_t;
  localparam logic [FS_W-1:0] RSV_NIBBLE = 4'b1110;

  function automatic logic is_reserved(input sel_code_t c);
    return c[FS_W-1:0] == RSV_NIBBLE;
  endfunction
endpackage

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
  parameter int WIN_CYC = 28636
) (
  input  logic clk,
  input  logic rst_n,
  output logic window_end,
  output logic done
);
  localparam int CNT_W = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign window_end = !done_q && (cnt_q == LAST);
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (window_end) begin
      done_q <= 1'b1;
    end else if (!done_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> (cnt_q <= LAST));
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import freq_strap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [FS_W-1:0] fs_pad,
  input  logic            sio_pad,
  output logic [FS_W-1:0] fs_q,
  output logic            sio_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_q  <= '0;
      sio_q <= 1'b0;
    end else if (capture) begin
      fs_q  <= fs_pad;
      sio_q <= sio_pad;
    end
  end

  // R3
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(fs_q) && $stable(sio_q)));
endmodule

// File: rtl/code_select.sv
module code_select
  import freq_strap_pkg::*;
#(
  parameter sel_code_t RESET_CODE = 5'b0_1101
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            override,
  input  sel_code_t       reg_code,
  input  logic [FS_W-1:0] fs_q,
  output sel_code_t       eff_q,
  output logic            upd_q,
  output logic            err_q
);
  sel_code_t raw;
  logic      raw_rsv;
  logic      loaded_q;

  always_comb begin
    raw     = override ? reg_code : {1'b0, fs_q};
    raw_rsv = is_reserved(raw);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_q    <= RESET_CODE;
      upd_q    <= 1'b0;
      err_q    <= 1'b0;
      loaded_q <= 1'b0;
    end else if (active) begin
      err_q <= raw_rsv;
      upd_q <= !raw_rsv && (!loaded_q || (raw != eff_q));
      if (!raw_rsv) begin
        eff_q    <= raw;
        loaded_q <= 1'b1;
      end
    end else begin
      upd_q <= 1'b0;
    end
  end

  // R7
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && raw_rsv) |=> ($stable(eff_q) && err_q && !upd_q));
  // R8
  quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && !upd_q) |-> $stable(eff_q));
  // R7
  never_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |-> !is_reserved(eff_q));
endmodule

// File: rtl/freq_strap_ctrl.sv
module freq_strap_ctrl
  import freq_strap_pkg::*;
#(
  parameter longint    REF_HZ     = 14_318_180,
  parameter int        WINDOW_US  = 2000,
  parameter sel_code_t RESET_CODE = 5'b0_1101
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FS_W-1:0] fs_pad_in,
  input  logic            sio_pad_in,
  output logic            pad_oe,
  output logic            sio_rate_24,
  input  logic            cfg_override,
  input  logic [CODE_W-1:0] cfg_sel,
  output logic [FS_W-1:0] freq_code,
  output logic            spread_en,
  output logic            code_err,
  output logic            code_upd
);
  localparam longint WIN_L   = (REF_HZ * longint'(WINDOW_US)) / 64'd1_000_000;
  localparam int     WIN_CYC = (WIN_L < 2) ? 2 : int'(WIN_L);

  logic            win_end, done;
  logic [FS_W-1:0] fs_q;
  sel_code_t       eff;

  strap_window_timer #(.WIN_CYC(WIN_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .window_end(win_end), .done(done)
  );

  strap_capture u_cap (
    .clk(clk), .rst_n(rst_n), .capture(win_end),
    .fs_pad(fs_pad_in), .sio_pad(sio_pad_in),
    .fs_q(fs_q), .sio_q(sio_rate_24)
  );

  code_select #(.RESET_CODE(RESET_CODE)) u_sel (
    .clk(clk), .rst_n(rst_n), .active(done), .override(cfg_override),
    .reg_code(cfg_sel), .fs_q(fs_q),
    .eff_q(eff), .upd_q(code_upd), .err_q(code_err)
  );

  assign pad_oe    = done;
  assign freq_code = eff[FS_W-1:0];
  assign spread_en = eff[CODE_W-1];

  // R1
  window_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_oe |-> (!code_upd && !code_err && (eff == RESET_CODE)));
  // R5
  no_spread_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pad_oe) && !$past(cfg_override) && !code_err) |-> !spread_en);
endmodule

// File: tb/freq_strap_ctrl_tb.sv
module freq_strap_ctrl_tb;
  localparam int WIN = 20;
  localparam logic [4:0] RST_CODE = 5'b0_1101;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] fs_pad_in = '0;
  logic       sio_pad_in = 1'b0;
  logic       cfg_override = 1'b0;
  logic [4:0] cfg_sel = '0;
  logic       pad_oe, sio_rate_24, spread_en, code_err, code_upd;
  logic [3:0] freq_code;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  freq_strap_ctrl #(.REF_HZ(1_000_000), .WINDOW_US(WIN), .RESET_CODE(RST_CODE)) u_dut (
    .clk(clk), .rst_n(rst_n), .fs_pad_in(fs_pad_in), .sio_pad_in(sio_pad_in),
    .pad_oe(pad_oe), .sio_rate_24(sio_rate_24), .cfg_override(cfg_override),
    .cfg_sel(cfg_sel), .freq_code(freq_code), .spread_en(spread_en),
    .code_err(code_err), .code_upd(code_upd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] outs();
    return {22'd0, pad_oe, sio_rate_24, code_err, code_upd, spread_en, freq_code};
  endfunction

  // apply a strap pattern through a full reset and window
  task automatic strap_run(input logic [3:0] fs, input logic sio);
    logic rsv;
    logic [3:0] exp_nib;
    rsv = (fs == 4'b1110);
    @(negedge clk);
    rst_n = 1'b0; fs_pad_in = fs; sio_pad_in = sio;
    cfg_override = 1'b0; cfg_sel = {1'b1, ~fs};
    repeat (2) @(negedge clk);
    chk("R1", outs(), {22'd0, 1'b0, 1'b0, 1'b0, 1'b0, RST_CODE});
    rst_n = 1'b1;
    repeat (WIN - 1) @(negedge clk);
    chk("R2", {31'd0, pad_oe}, 32'd0);
    chk("R1", outs(), {22'd0, 1'b0, 1'b0, 1'b0, 1'b0, RST_CODE});
    @(negedge clk);
    chk("R2", {31'd0, pad_oe}, 32'd1);
    chk("R4", {31'd0, sio_rate_24}, {31'd0, sio});
    fs_pad_in = ~fs; sio_pad_in = ~sio;
    @(negedge clk);
    exp_nib = rsv ? RST_CODE[3:0] : fs;
    // R9 R5 R7 R8: registered one edge after latch; first accept strobes
    chk("R5", {27'd0, spread_en, freq_code}, {27'd0, rsv ? RST_CODE[4] : 1'b0, exp_nib});
    chk("R7", {31'd0, code_err}, {31'd0, rsv});
    chk("R8", {31'd0, code_upd}, {31'd0, !rsv});
    @(negedge clk);
    chk("R3", {27'd0, sio_rate_24, freq_code}, {27'd0, sio, exp_nib});
    chk("R8", {31'd0, code_upd}, 32'd0);
    cfg_sel = ~cfg_sel;
    @(negedge clk);
    chk("R5", {28'd0, freq_code}, {28'd0, exp_nib});
    chk("R5", {30'd0, code_upd, spread_en}, 32'd0);
  endtask

  initial begin
    logic [4:0] prev;
    logic [4:0] s5;
    logic       rsv;
    for (int i = 0; i < 32; i++) strap_run(i[3:0], i[4]);

    // override sweep over all register codes
    strap_run(4'b0101, 1'b0);
    prev = 5'b0_0101;
    cfg_override = 1'b1;
    for (int s = 0; s < 32; s++) begin
      s5 = s[4:0];
      cfg_sel = s5;
      @(negedge clk);
      rsv = (s5[3:0] == 4'b1110);
      chk("R6", {27'd0, spread_en, freq_code}, {27'd0, rsv ? prev : s5});
      chk("R7", {31'd0, code_err}, {31'd0, rsv});
      chk("R8", {31'd0, code_upd}, {31'd0, !rsv && (s5 != prev)});
      if (!rsv) prev = s5;
    end
    // hold: no further strobe
    @(negedge clk);
    chk("R8", {31'd0, code_upd}, 32'd0);
    // reserved then recover
    cfg_sel = 5'b1_1110;
    @(negedge clk);
    chk("R7", {29'd0, code_err, spread_en, 1'b0}, {29'd0, 1'b1, prev[4], 1'b0});
    chk("R7", {28'd0, freq_code}, {28'd0, prev[3:0]});
    cfg_sel = 5'b1_0011;
    @(negedge clk);
    chk("R7", {31'd0, code_err}, 32'd0);
    chk("R6", {27'd0, spread_en, freq_code}, {27'd0, 5'b1_0011});
    chk("R8", {31'd0, code_upd}, 32'd1);
    // back to straps (latched 0101)
    cfg_override = 1'b0;
    @(negedge clk);
    chk("R5", {27'd0, spread_en, freq_code}, {27'd0, 5'b0_0101});
    chk("R8", {31'd0, code_upd}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule